// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching two words from a page table tree held in memory. The root of the tree is a base register. Software can reload that register to switch address spaces. Each request is accepted through a valid/ready handshake, and the block then starts its walk.

The walk has two reads. The top ten address bits select a word in the directory page, and that word names the frame of a second-level table. The next ten bits select a word in that table. The second word supplies the physical frame, and the low twelve bits of the virtual address are appended to it unchanged.

If an entry is absent, or the page is paged out, or a write targets a read-only page, the walk ends with a fault. The fault carries one of three distinct causes and the program counter of the access, so a handler can replay the access. The memory side is a single-outstanding read port: a request with valid/ready, then a response strobe that carries the data word.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_rd_valid` and `resp_valid` are 0.
- R2: The first read of a walk goes to `{root_frame, va[31:22], 2'b00}`. `root_frame` is bits 31:12 of the base register. Every read address is word aligned.
- R3: The second read goes to `{dir_entry[31:12], va[21:12], 2'b00}`. It is issued only after the directory word has returned.
- R4: A good walk returns `resp_fault`=0, `resp_cause`=0 and `resp_paddr = {leaf_entry[31:12], va[11:0]}`. With a memory that accepts at once and answers one cycle later, `resp_valid` rises 5 cycles after the accepting clock edge.
- R5: A directory word with bit 0 (present) clear ends the walk with cause 1 (invalid) after one read. `resp_valid` rises 3 cycles after acceptance.
- R6: A leaf word with bit 0 clear gives cause 1 (invalid).
- R7: A leaf word with bit 0 set and bit 2 (resident) clear gives cause 2 (non-resident). This cause wins over a protection failure.
- R8: A write (`req_write`=1) to a present, resident leaf whose bit 1 (writable) is clear gives cause 3 (protection). A read of the same page translates normally.
- R9: `resp_valid` is a one-cycle pulse. On a fault, `resp_fault`=1 and `resp_paddr`=0. `resp_pc` always equals the `req_pc` captured at acceptance.
- R10: `base_load` updates the base register only while `req_ready` is 1, and the next walk uses the new root. While a walk is in progress, `base_load` is ignored.
- R11: `req_ready` stays 0 from acceptance until the response cycle ends. While `mem_rd_ready` is 0, a pending read keeps `mem_rd_valid` at 1 and `mem_rd_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_load | input | 1 | Load the base register (honoured only while idle) |
| base_value | input | 32 | New base address; bits 31:12 are the root frame |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access |
| req_pc | input | 32 | Program counter of the access |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Returned table word |
| resp_valid | output | 1 | Translation result pulse |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_cause | output | 2 | 0 none, 1 invalid, 2 non-resident, 3 protection |
| resp_pc | output | 32 | Program counter of the translated access |

## Verification
The bench builds the walker with its default split of ten directory bits, ten table bits and twelve offset bits. With this split it can use a table whose last directory slot and last leaf slot are both filled, which puts the all-ones virtual address within reach. The bench checks both read addresses, the latency and the fault cause for each table case. It also drives base-register reloads at idle and mid-walk, and a stalled memory acceptance, and checks that the held read and the latency stretch by the stall.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_WT_DIR,
        ST_RD_LEAF,
        ST_WT_LEAF,
        ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_INVALID  = 2'd1,
        CAUSE_ABSENT   = 2'd2,
        CAUSE_PROTECT  = 2'd3
    } cause_e;

    localparam int unsigned BIT_PRESENT  = 0;
    localparam int unsigned BIT_WRITABLE = 1;
    localparam int unsigned BIT_RESIDENT = 2;

endpackage

// File: rtl/pt_entry_check.sv
module pt_entry_check
    import pt_walker_pkg::*;
#(
    parameter int unsigned ENTRY_W  = 32,
    parameter int unsigned OFF_BITS = 12,
    parameter bit          IS_LEAF  = 1'b0
) (
    input  logic [ENTRY_W-1:0]          entry,
    input  logic                        is_write,
    output cause_e                      cause,
    output logic [ENTRY_W-OFF_BITS-1:0] frame
);
    assign frame = entry[ENTRY_W-1:OFF_BITS];

    generate
        if (IS_LEAF) begin : g_leaf
            always_comb begin
                if (!entry[BIT_PRESENT]) begin
                    cause = CAUSE_INVALID;
                end else if (!entry[BIT_RESIDENT]) begin
                    cause = CAUSE_ABSENT;
                end else if (is_write && !entry[BIT_WRITABLE]) begin
                    cause = CAUSE_PROTECT;
                end else begin
                    cause = CAUSE_NONE;
                end
            end
        end else begin : g_dir
            logic unused_wr;
            assign unused_wr = is_write;
            always_comb begin
                cause = entry[BIT_PRESENT] ? CAUSE_NONE : CAUSE_INVALID;
            end
        end
    endgenerate

endmodule

// File: rtl/pt_addr_form.sv
module pt_addr_form #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned OFF_BITS = 12,
    parameter int unsigned IDX_BITS = 10,
    parameter int unsigned IDX_LSB  = 12
) (
    input  logic [ADDR_W-OFF_BITS-1:0] frame,
    input  logic [ADDR_W-1:0]          vaddr,
    output logic [ADDR_W-1:0]          addr
);
    localparam int unsigned WORD_SHIFT = 2;

    logic [IDX_BITS-1:0] idx;
    logic [ADDR_W-1:0]   page_base;
    logic [ADDR_W-1:0]   word_off;

    assign idx       = vaddr[IDX_LSB +: IDX_BITS];
    assign page_base = {frame, {OFF_BITS{1'b0}}};
    assign word_off  = ADDR_W'({idx, {WORD_SHIFT{1'b0}}});
    assign addr      = page_base | word_off;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int unsigned DIR_BITS  = 10,
    parameter int unsigned LEAF_BITS = 10,
    parameter int unsigned OFF_BITS  = 12,
    parameter int unsigned PC_W      = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  base_load,
    input  logic [DIR_BITS+LEAF_BITS+OFF_BITS-1:0] base_value,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic [DIR_BITS+LEAF_BITS+OFF_BITS-1:0] req_vaddr,
    input  logic                                  req_write,
    input  logic [PC_W-1:0]                       req_pc,
    output logic                                  mem_rd_valid,
    input  logic                                  mem_rd_ready,
    output logic [DIR_BITS+LEAF_BITS+OFF_BITS-1:0] mem_rd_addr,
    input  logic                                  mem_rsp_valid,
    input  logic [DIR_BITS+LEAF_BITS+OFF_BITS-1:0] mem_rsp_data,
    output logic                                  resp_valid,
    output logic [DIR_BITS+LEAF_BITS+OFF_BITS-1:0] resp_paddr,
    output logic                                  resp_fault,
    output logic [1:0]                            resp_cause,
    output logic [PC_W-1:0]                       resp_pc
);
    localparam int unsigned VA_W    = DIR_BITS + LEAF_BITS + OFF_BITS;
    localparam int unsigned FRAME_W = VA_W - OFF_BITS;

    typedef struct packed {
        walk_st_e           st;
        logic [VA_W-1:0]    va;
        logic               wr;
        logic [PC_W-1:0]    pc;
        logic [FRAME_W-1:0] root;
        logic [FRAME_W-1:0] leaf_tbl;
        logic [VA_W-1:0]    pa;
        cause_e             cause;
    } walk_reg_t;

    walk_reg_t r_q, r_d;

    logic [VA_W-1:0]    dir_addr;
    logic [VA_W-1:0]    leaf_addr;
    cause_e             dir_cause;
    cause_e             leaf_cause;
    logic [FRAME_W-1:0] dir_frame;
    logic [FRAME_W-1:0] leaf_frame;

    // Directory word address from the root frame and the top index field.
    pt_addr_form #(
        .ADDR_W  (VA_W),
        .OFF_BITS(OFF_BITS),
        .IDX_BITS(DIR_BITS),
        .IDX_LSB (OFF_BITS + LEAF_BITS)
    ) u_dir_addr (
        .frame(r_q.root),
        .vaddr(r_q.va),
        .addr (dir_addr)
    );

    // Leaf word address from the table frame and the middle index field.
    pt_addr_form #(
        .ADDR_W  (VA_W),
        .OFF_BITS(OFF_BITS),
        .IDX_BITS(LEAF_BITS),
        .IDX_LSB (OFF_BITS)
    ) u_leaf_addr (
        .frame(r_q.leaf_tbl),
        .vaddr(r_q.va),
        .addr (leaf_addr)
    );

    pt_entry_check #(
        .ENTRY_W (VA_W),
        .OFF_BITS(OFF_BITS),
        .IS_LEAF (1'b0)
    ) u_dir_chk (
        .entry   (mem_rsp_data),
        .is_write(r_q.wr),
        .cause   (dir_cause),
        .frame   (dir_frame)
    );

    pt_entry_check #(
        .ENTRY_W (VA_W),
        .OFF_BITS(OFF_BITS),
        .IS_LEAF (1'b1)
    ) u_leaf_chk (
        .entry   (mem_rsp_data),
        .is_write(r_q.wr),
        .cause   (leaf_cause),
        .frame   (leaf_frame)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (base_load) begin
                    r_d.root = base_value[VA_W-1:OFF_BITS];
                end
                if (req_valid) begin
                    r_d.va    = req_vaddr;
                    r_d.wr    = req_write;
                    r_d.pc    = req_pc;
                    r_d.pa    = '0;
                    r_d.cause = CAUSE_NONE;
                    r_d.st    = ST_RD_DIR;
                end
            end
            ST_RD_DIR: begin
                if (mem_rd_ready) begin
                    r_d.st = ST_WT_DIR;
                end
            end
            ST_WT_DIR: begin
                if (mem_rsp_valid) begin
                    if (dir_cause != CAUSE_NONE) begin
                        r_d.cause = dir_cause;
                        r_d.st    = ST_DONE;
                    end else begin
                        r_d.leaf_tbl = dir_frame;
                        r_d.st       = ST_RD_LEAF;
                    end
                end
            end
            ST_RD_LEAF: begin
                if (mem_rd_ready) begin
                    r_d.st = ST_WT_LEAF;
                end
            end
            ST_WT_LEAF: begin
                if (mem_rsp_valid) begin
                    r_d.cause = leaf_cause;
                    if (leaf_cause == CAUSE_NONE) begin
                        r_d.pa = {leaf_frame, r_q.va[OFF_BITS-1:0]};
                    end
                    r_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cause: CAUSE_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = (r_q.st == ST_IDLE);
    assign mem_rd_valid = (r_q.st == ST_RD_DIR) || (r_q.st == ST_RD_LEAF);
    assign mem_rd_addr  = (r_q.st == ST_RD_LEAF) ? leaf_addr : dir_addr;
    assign resp_valid   = (r_q.st == ST_DONE);
    assign resp_paddr   = r_q.pa;
    assign resp_fault   = (r_q.cause != CAUSE_NONE);
    assign resp_cause   = r_q.cause;
    assign resp_pc      = r_q.pc;

    // Views of internal state for the bound checker.
    logic [FRAME_W-1:0]  root_cur;
    logic [OFF_BITS-1:0] va_off_cur;
    assign root_cur   = r_q.root;
    assign va_off_cur = r_q.va[OFF_BITS-1:0];

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned OFF_BITS = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_ready,
    input logic                       mem_rd_valid,
    input logic                       mem_rd_ready,
    input logic [ADDR_W-1:0]          mem_rd_addr,
    input logic                       resp_valid,
    input logic                       resp_fault,
    input logic [ADDR_W-1:0]          resp_paddr,
    input logic [ADDR_W-OFF_BITS-1:0] root_cur,
    input logic [OFF_BITS-1:0]        va_off_cur
);
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R11
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready); // R11
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00); // R2
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R9
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_fault |-> resp_paddr == '0); // R9
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_fault |-> resp_paddr[OFF_BITS-1:0] == va_off_cur); // R4
    AST_ROOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> root_cur == $past(root_cur)); // R10
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr (mem_rd_addr),
    .resp_valid  (resp_valid),
    .resp_fault  (resp_fault),
    .resp_paddr  (resp_paddr),
    .root_cur    (root_cur),
    .va_off_cur  (va_off_cur)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_load = 1'b0;
    logic [31:0] base_value = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_pc = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b1;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_fault;
    logic [1:0]  resp_cause;
    logic [31:0] resp_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_value(base_value),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_pc(req_pc), .mem_rd_valid(mem_rd_valid),
        .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .resp_cause(resp_cause), .resp_pc(resp_pc)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Table memory model: accepts at once unless stalled, answers one cycle later.
    logic [31:0] mem [logic [31:0]];
    bit          pending = 0;
    logic [31:0] pend_addr = '0;
    int          stall = 0;
    int          nreads = 0;
    logic [31:0] rd_log [2];
    int          addr_moved = 0;
    logic [31:0] stall_addr = '0;

    function automatic logic [31:0] lookup(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pending) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = lookup(pend_addr);
            pending       = 0;
        end else if (mem_rd_valid) begin
            if (stall > 0) begin
                if (mem_rd_ready == 1'b0 && mem_rd_addr != stall_addr) addr_moved++;
                stall_addr   = mem_rd_addr;
                stall        = stall - 1;
                mem_rd_ready = 1'b0;
            end else begin
                if (mem_rd_ready == 1'b0 && mem_rd_addr != stall_addr) addr_moved++;
                mem_rd_ready = 1'b1;
                pending      = 1;
                pend_addr    = mem_rd_addr;
                if (nreads < 2) rd_log[nreads] = mem_rd_addr;
                nreads++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // One translation; returns result fields and cycles from acceptance to response.
    task automatic walk(input logic [31:0] va, input bit wr, input logic [31:0] pc,
                        input bit poke_base, output logic [31:0] pa, output logic f,
                        output logic [1:0] cause, output logic [31:0] rpc,
                        output int cyc);
        @(negedge clk);
        nreads     = 0;
        rd_log[0]  = '0;
        rd_log[1]  = '0;
        req_valid  = 1'b1;
        req_vaddr  = va;
        req_write  = wr;
        req_pc     = pc;
        @(posedge clk);
        cyc = 1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid && cyc < 100) begin
            if (poke_base && cyc == 2) begin
                check(req_ready == 1'b0, "R11 ready low mid-walk", 32'(req_ready), 32'h0);
                base_load  = 1'b1;
                base_value = 32'h0006_0000;
            end else begin
                base_load = 1'b0;
            end
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        base_load = 1'b0;
        pa    = resp_paddr;
        f     = resp_fault;
        cause = resp_cause;
        rpc   = resp_pc;
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [1:0]  cause;
        logic [31:0] pa;
        logic [1:0]  nrd;
        logic [31:0] a1;
        logic [31:0] a2;
    } vec_t;

    // cause: 0 none, 1 invalid, 2 non-resident, 3 protection
    localparam vec_t VECS [8] = '{
        '{32'h0040_0ABC, 1'b0, 2'd0, 32'h1234_5ABC, 2'd2, 32'h0001_0004, 32'h0002_0000}, // R4
        '{32'h0040_0ABC, 1'b1, 2'd0, 32'h1234_5ABC, 2'd2, 32'h0001_0004, 32'h0002_0000}, // R4
        '{32'h0040_1123, 1'b0, 2'd0, 32'h0ABC_D123, 2'd2, 32'h0001_0004, 32'h0002_0004}, // R8 read ok
        '{32'h0040_1123, 1'b1, 2'd3, 32'h0000_0000, 2'd2, 32'h0001_0004, 32'h0002_0004}, // R8
        '{32'h0040_2000, 1'b0, 2'd1, 32'h0000_0000, 2'd2, 32'h0001_0004, 32'h0002_0008}, // R6
        '{32'h0040_3FFF, 1'b1, 2'd2, 32'h0000_0000, 2'd2, 32'h0001_0004, 32'h0002_000C}, // R7
        '{32'h0080_0000, 1'b0, 2'd1, 32'h0000_0000, 2'd1, 32'h0001_0008, 32'h0000_0000}, // R5
        '{32'hFFFF_FFFF, 1'b1, 2'd0, 32'hFFFF_FFFF, 2'd2, 32'h0001_0FFC, 32'h0003_0FFC}  // R4 max
    };

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] pa, rpc;
        logic        f;
        logic [1:0]  cause;
        int          cyc;

        mem[32'h0001_0004] = 32'h0002_0001;
        mem[32'h0001_0008] = 32'h0000_0000;
        mem[32'h0001_0FFC] = 32'h0003_0001;
        mem[32'h0002_0000] = 32'h1234_5007;
        mem[32'h0002_0004] = 32'h0ABC_D005;
        mem[32'h0002_0008] = 32'h0000_0006;
        mem[32'h0002_000C] = 32'h0077_7001;
        mem[32'h0003_0FFC] = 32'hFFFF_F007;
        mem[32'h0004_0004] = 32'h0005_0001;
        mem[32'h0005_0000] = 32'h0099_9007;
        mem[32'h0006_0004] = 32'h0007_0001;
        mem[32'h0007_0000] = 32'h0088_8007;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'h1);
        check(mem_rd_valid == 1'b0, "R1 mem_rd_valid", 32'(mem_rd_valid), 32'h0);
        check(resp_valid == 1'b0, "R1 resp_valid", 32'(resp_valid), 32'h0);

        // load root 0x10000 while idle (R10)
        base_load  = 1'b1;
        base_value = 32'h0001_0000;
        @(negedge clk);
        base_load = 1'b0;

        foreach (VECS[i]) begin
            logic [31:0] pcv;
            pcv = 32'h8000_0000 + 32'(i) * 4;
            walk(VECS[i].va, VECS[i].wr, pcv, 1'b0, pa, f, cause, rpc, cyc);
            check(cause == VECS[i].cause, $sformatf("R6/R7/R8 cause vec%0d", i),
                  32'(cause), 32'(VECS[i].cause));
            check(f == (VECS[i].cause != 0), $sformatf("R9 fault vec%0d", i),
                  32'(f), 32'(VECS[i].cause != 0));
            check(pa == VECS[i].pa, $sformatf("R4 paddr vec%0d", i), pa, VECS[i].pa);
            check(rpc == pcv, $sformatf("R9 pc vec%0d", i), rpc, pcv);
            check(nreads == int'(VECS[i].nrd), $sformatf("R5 read count vec%0d", i),
                  32'(nreads), 32'(VECS[i].nrd));
            check(rd_log[0] == VECS[i].a1, $sformatf("R2 dir addr vec%0d", i),
                  rd_log[0], VECS[i].a1);
            if (VECS[i].nrd == 2) begin
                check(rd_log[1] == VECS[i].a2, $sformatf("R3 leaf addr vec%0d", i),
                      rd_log[1], VECS[i].a2);
                check(cyc == 5, $sformatf("R4 latency vec%0d", i), 32'(cyc), 32'd5);
            end else begin
                check(cyc == 3, $sformatf("R5 latency vec%0d", i), 32'(cyc), 32'd3);
            end
            @(negedge clk);
            check(resp_valid == 1'b0, $sformatf("R9 pulse vec%0d", i), 32'(resp_valid), 32'h0);
        end

        // R11: stalled acceptance stretches latency and holds the address
        stall = 3;
        addr_moved = 0;
        walk(32'h0040_0ABC, 1'b0, 32'h1111_0000, 1'b0, pa, f, cause, rpc, cyc);
        check(cyc == 8, "R11 stall latency", 32'(cyc), 32'd8);
        check(addr_moved == 0, "R11 held address", 32'(addr_moved), 32'h0);
        check(pa == 32'h1234_5ABC, "R11 stall paddr", pa, 32'h1234_5ABC);

        // R10: switch address space by loading a new root while idle
        @(negedge clk);
        base_load  = 1'b1;
        base_value = 32'h0004_0000;
        @(negedge clk);
        base_load = 1'b0;
        walk(32'h0040_0010, 1'b0, 32'h2222_0000, 1'b0, pa, f, cause, rpc, cyc);
        check(rd_log[0] == 32'h0004_0004, "R10 new root dir addr", rd_log[0], 32'h0004_0004);
        check(pa == 32'h0099_9010, "R10 new root paddr", pa, 32'h0099_9010);

        // R10: load attempt during a walk is ignored
        walk(32'h0040_0010, 1'b1, 32'h3333_0000, 1'b1, pa, f, cause, rpc, cyc);
        check(pa == 32'h0099_9010, "R10 walk with poke", pa, 32'h0099_9010);
        walk(32'h0040_0010, 1'b0, 32'h4444_0000, 1'b0, pa, f, cause, rpc, cyc);
        check(rd_log[0] == 32'h0004_0004, "R10 busy load ignored", rd_log[0], 32'h0004_0004);
        check(pa == 32'h0099_9010, "R10 root unchanged paddr", pa, 32'h0099_9010);

        summary();
    end
endmodule